// File: doc/BRIEF.md
# SDRAM Single-Access Sequencer

This block carries out one SDR SDRAM access at a time, either a single read or a single write. It takes a request on a valid/ready handshake. The request holds a flat 24-bit word address, a write flag and 16 bits of write data. The block splits the address into bank, row and column fields. It opens the row with an activate command and waits a fixed number of cycles. It then issues the column command with auto-precharge requested. After that it waits for the precharge to complete before it accepts the next request. Read data comes back on a one-cycle valid pulse, a fixed number of cycles after the read command.

The request interface follows valid/ready rules. A request is taken only in a cycle where `req_valid` and `req_ready` are both high. The fields are captured in that cycle, so the requester may change them afterwards. While `req_ready` is low, `req_valid` may stay high and the request waits. The read return carries no back-pressure, because the memory cannot be stalled. The consumer must take `rd_data` in the cycle `rd_valid` is high.

The device is assumed to be initialised already, and refresh is left to other logic. The data bus is split into output, output-enable and input, to be joined at a tri-state pad.

Top module: `sdram_access_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is accepted only when `req_valid` and `req_ready` are both high. Address, write flag and data are captured at acceptance, and later changes to the request pins have no effect on that access.
- R2: The flat address splits as bank = bits 23:22, row = bits 21:9 and column = bits 8:0.
- R3: In the cycle after acceptance the block issues activate: `{sd_cs_n,sd_ras_n,sd_cas_n,sd_we_n}` = 4'b0011, with `sd_ba` set to the bank and `sd_a` set to the row.
- R4: The column command comes exactly TRCD cycles after the activate (default 2). The cycles in between carry NOP.
- R5: The column command is 4'b0100 for a write and 4'b0101 for a read, in the order cs_n, ras_n, cas_n, we_n. It carries the same bank. `sd_a[8:0]` holds the column, `sd_a[10]` is 1 (auto-precharge), and every other address bit is 0.
- R6: Every cycle that is neither activate nor column command is a NOP, 4'b0111. Chip select is low in every cycle, `sd_cke` is always 1 and `sd_dqm` is always 0.
- R7: `sd_dq_oe` is high only in the write-command cycle, and in that cycle `sd_dq_o` equals the captured write data.
- R8: For a read command in cycle c, the block samples `sd_dq_i` at the clock edge that ends cycle c+CAS_LATENCY (default 2). In cycle c+CAS_LATENCY+1, `rd_valid` is high for exactly one cycle and `rd_data` holds the sampled value.
- R9: After the column command, `req_ready` stays low for TRP_TWR cycles (default 4) and rises in the cycle after them.
- R10: While idle with `req_valid` low, the block issues only NOP and `req_ready` stays high, whatever the other request pins do.
- R11: During and right after reset, `req_ready` is 1, the command is NOP, `rd_valid` is 0 and `sd_dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the device |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Flat word address |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle read return strobe |
| rd_data | output | 16 | Read return data |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 13 | Multiplexed row/column address |
| sd_dq_o | output | 16 | Data toward the pad |
| sd_dq_oe | output | 1 | Pad output enable |
| sd_dq_i | input | 16 | Data from the pad |
| sd_dqm | output | 2 | Byte mask, held low |

## Verification
Directed accesses go to the address extremes: all zeros, all ones, each bank boundary and the last column. These show whether each field is sliced out of the right bits and whether A10 stays apart from the column. A random series of writes, followed by reads of the same addresses and of unwritten ones, checks every command cycle against the address split and the timing gaps. While an access is running, the request pins are scrambled every cycle, which exposes any path that bypasses the captured copy. In the read cycles the bench puts the expected word on the data input only in the capture cycle and the inverted word in all other cycles. A capture taken one cycle early or late therefore shows up as a wrong value.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_RCD,
    ST_COL,
    ST_PRE
  } seq_state_t;

  // command word order: cs_n, ras_n, cas_n, we_n
  typedef logic [3:0] sd_cmd_t;
  localparam sd_cmd_t CMD_NOP = 4'b0111;
  localparam sd_cmd_t CMD_ACT = 4'b0011;
  localparam sd_cmd_t CMD_RD  = 4'b0101;
  localparam sd_cmd_t CMD_WR  = 4'b0100;
endpackage

// File: rtl/sdram_addr_split.sv
`timescale 1ns/1ps
module sdram_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  // bank on top, then row, column in the low bits
  assign bank = addr[ADDR_W-1 -: BANK_W];
  assign row  = addr[COL_W +: ROW_W];
  assign col  = addr[COL_W-1:0];
endmodule

// File: rtl/sdram_cmd_fsm.sv
`timescale 1ns/1ps
module sdram_cmd_fsm
  import sdram_seq_pkg::*;
#(
  parameter int TRCD    = 2,
  parameter int TRP_TWR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  output seq_state_t state
);
  localparam int MAXW = (TRCD > TRP_TWR) ? TRCD : TRP_TWR;
  localparam int CW   = $clog2(MAXW + 1) + 1;

  seq_state_t      nxt;
  logic [CW-1:0]   cnt;

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req_valid) nxt = ST_ACT;
      ST_ACT:  nxt = (TRCD > 1) ? ST_RCD : ST_COL;
      ST_RCD:  if (cnt == CW'(1)) nxt = ST_COL;
      ST_COL:  nxt = ST_PRE;
      ST_PRE:  if (cnt == CW'(1)) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      unique case (state)
        ST_ACT:         cnt <= CW'(TRCD - 1);
        ST_COL:         cnt <= CW'(TRP_TWR);
        ST_RCD, ST_PRE: cnt <= cnt - CW'(1);
        default:        cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sdram_rd_capture.sv
`timescale 1ns/1ps
module sdram_rd_capture #(
  parameter int DQ_W        = 16,
  parameter int CAS_LATENCY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issue,
  input  logic [DQ_W-1:0] dq_i,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data
);
  logic [CAS_LATENCY-1:0] pipe;
  logic                   hit;

  generate
    if (CAS_LATENCY == 1) begin : g_cl1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= rd_issue;
      end
    end else begin : g_cln
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[CAS_LATENCY-2:0], rd_issue};
      end
    end
  endgenerate

  assign hit = pipe[CAS_LATENCY-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= hit;
      if (hit) rd_data <= dq_i;
    end
  end
endmodule

// File: rtl/sdram_access_seq.sv
`timescale 1ns/1ps
module sdram_access_seq #(
  parameter int BANK_W      = 2,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 9,
  parameter int DQ_W        = 16,
  parameter int AP_BIT      = 10,
  parameter int TRCD        = 2,
  parameter int CAS_LATENCY = 2,
  parameter int TRP_TWR     = 4,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int DM_W   = DQ_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQ_W-1:0]   req_wdata,
  output logic              rd_valid,
  output logic [DQ_W-1:0]   rd_data,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [DQ_W-1:0]   sd_dq_o,
  output logic              sd_dq_oe,
  input  logic [DQ_W-1:0]   sd_dq_i,
  output logic [DM_W-1:0]   sd_dqm
);
  import sdram_seq_pkg::*;

  seq_state_t        st;
  logic              take;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  sd_cmd_t           cmd;
  logic              rd_issue;

  assign take = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (take) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  sdram_addr_split #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_split (
    .addr(addr_q), .bank(bank), .row(row), .col(col)
  );

  sdram_cmd_fsm #(
    .TRCD(TRCD), .TRP_TWR(TRP_TWR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_ready(req_ready), .state(st)
  );

  always_comb begin
    cmd      = CMD_NOP;
    sd_ba    = '0;
    sd_a     = '0;
    sd_dq_oe = 1'b0;
    sd_dq_o  = '0;
    unique case (st)
      ST_ACT: begin
        cmd   = CMD_ACT;
        sd_ba = bank;
        sd_a  = row;
      end
      ST_COL: begin
        cmd              = wr_q ? CMD_WR : CMD_RD;
        sd_ba            = bank;
        sd_a[COL_W-1:0]  = col;
        sd_a[AP_BIT]     = 1'b1;
        if (wr_q) begin
          sd_dq_oe = 1'b1;
          sd_dq_o  = wdata_q;
        end
      end
      default: ;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_cke   = 1'b1;
  assign sd_dqm   = '0;
  assign rd_issue = (st == ST_COL) && !wr_q;

  sdram_rd_capture #(
    .DQ_W(DQ_W), .CAS_LATENCY(CAS_LATENCY)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue),
    .dq_i(sd_dq_i), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/sdram_access_seq_checker.sv
`timescale 1ns/1ps
module sdram_access_seq_checker #(
  parameter int TRCD = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic sd_cke,
  input logic sd_cs_n,
  input logic sd_ras_n,
  input logic sd_cas_n,
  input logic sd_we_n,
  input logic sd_a_ap,
  input logic sd_dq_oe
);
  localparam int GW = $clog2(TRCD + 2) + 1;

  logic          is_act;
  logic          is_col;
  logic [GW-1:0] gap;

  assign is_act = !sd_cs_n && !sd_ras_n && sd_cas_n && sd_we_n;
  assign is_col = !sd_cs_n && sd_ras_n && !sd_cas_n;

  // cycles since the last activate, saturating just past TRCD
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gap <= '0;
    else if (is_act)                    gap <= GW'(1);
    else if (gap != '0 && gap <= GW'(TRCD)) gap <= gap + GW'(1);
  end

  p_cs_low_r6: assert property (@(posedge clk) disable iff (!rst_n) !sd_cs_n);
  p_cke_high_r6: assert property (@(posedge clk) disable iff (!rst_n) sd_cke);
  p_ready_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sd_ras_n && sd_cas_n && sd_we_n));
  p_col_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (gap == GW'(TRCD)));
  p_autopre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> sd_a_ap);
  p_dq_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (is_col && !sd_we_n));
  p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

bind sdram_access_seq sdram_access_seq_checker #(.TRCD(TRCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_a_ap(sd_a[AP_BIT]),
  .sd_dq_oe(sd_dq_oe)
);

// File: tb/sdram_access_seq_tb.sv
`timescale 1ns/1ps
module sdram_access_seq_tb;
  localparam int TRCD = 2;
  localparam int CL   = 2;
  localparam int TPW  = 4;
  localparam int LAST = (TPW > CL + 1) ? TPW : CL + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [12:0] sd_a;
  logic [15:0] sd_dq_o;
  logic        sd_dq_oe;
  logic [15:0] sd_dq_i = '0;
  logic [1:0]  sd_dqm;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  bit [15:0] mem [int unsigned];
  logic [23:0] wlist [$];

  always #10 clk = ~clk;

  sdram_access_seq #(.TRCD(TRCD), .CAS_LATENCY(CL), .TRP_TWR(TPW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_o(sd_dq_o),
    .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i), .sd_dqm(sd_dqm)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] cmd_now();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  function automatic logic [15:0] mem_rd(input logic [23:0] a);
    if (mem.exists(a)) return mem[a];
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [12:0] col_addr(input logic [23:0] a);
    return 13'h0400 | {4'b0, a[8:0]};
  endfunction

  task automatic chk_nop(input string req);
    chk(req, "nop cmd", cmd_now(), 4'b0111);
    chk("R6", "cke", sd_cke, 1'b1);
    chk("R6", "dqm", sd_dqm, 2'b00);
  endtask

  task automatic scramble();
    req_addr  = $urandom;
    req_write = $urandom;
    req_wdata = $urandom;
  endtask

  task automatic access(input bit wr, input logic [23:0] addr, input logic [15:0] wd);
    logic [15:0] exp_rd;
    @(negedge clk);
    chk("R1", "ready before request", req_ready, 1'b1);
    chk_nop("R10");
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; scramble();
    chk("R3", "act cmd", cmd_now(), 4'b0011);
    chk("R2", "act bank", sd_ba, addr[23:22]);
    chk("R2", "act row", sd_a, addr[21:9]);
    chk("R1", "ready busy", req_ready, 1'b0);
    chk("R7", "oe at act", sd_dq_oe, 1'b0);
    for (int k = 1; k < TRCD; k++) begin
      @(negedge clk); scramble();
      chk_nop("R4");
    end
    @(negedge clk); scramble();
    chk("R5", "col cmd", cmd_now(), wr ? 4'b0100 : 4'b0101);
    chk("R2", "col bank", sd_ba, addr[23:22]);
    chk("R5", "col addr", sd_a, col_addr(addr));
    chk("R7", "oe at col", sd_dq_oe, wr);
    if (wr) begin
      chk("R7", "write data", sd_dq_o, wd);
      mem[addr] = wd;
    end
    exp_rd = mem_rd(addr);
    for (int k = 1; k <= LAST; k++) begin
      @(negedge clk); scramble();
      sd_dq_i = (!wr && k == CL) ? exp_rd : ~exp_rd;
      chk_nop("R6");
      chk("R7", "oe idle", sd_dq_oe, 1'b0);
      chk("R9", "ready after col", req_ready, (k > TPW));
      chk("R8", "rd_valid", rd_valid, (!wr && k == CL + 1));
      if (!wr && k == CL + 1) chk("R8", "rd_data", rd_data, exp_rd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) begin
      @(negedge clk);
      chk("R11", "ready in reset", req_ready, 1'b1);
      chk_nop("R11");
      chk("R11", "rd_valid in reset", rd_valid, 1'b0);
      chk("R11", "oe in reset", sd_dq_oe, 1'b0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "ready after reset", req_ready, 1'b1);
    // idle with valid low: pins wiggle, nothing happens
    for (int i = 0; i < 6; i++) begin
      scramble();
      @(negedge clk);
      chk_nop("R10");
      chk("R10", "ready idle", req_ready, 1'b1);
      chk("R10", "oe idle", sd_dq_oe, 1'b0);
    end
    // directed corners
    access(1, 24'h000000, 16'h1234);
    access(1, 24'hFFFFFF, 16'hBEEF);
    access(1, 24'h400000, 16'h0F0F);
    access(1, 24'h8001FF, 16'hF00D);
    access(1, 24'h3FFE00, 16'hA55A);
    access(0, 24'hFFFFFF, 16'h0);
    access(0, 24'h000000, 16'h0);
    access(0, 24'h8001FF, 16'h0);
    access(0, 24'h3FFE00, 16'h0);
    access(0, 24'h400000, 16'h0);
    access(0, 24'hC00155, 16'h0);
    // random writes then read-back
    for (int i = 0; i < 40; i++) begin
      logic [23:0] a;
      a = $urandom;
      wlist.push_back(a);
      access(1, a, 16'($urandom));
    end
    foreach (wlist[i]) access(0, wlist[i], 16'h0);
    for (int i = 0; i < 8; i++) access(0, 24'($urandom), 16'h0);
    @(negedge clk);
    chk("R9", "ready at end", req_ready, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule